// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block is the home-node directory for a small set of memory lines in a shared-memory multiprocessor. Each line's entry tracks one of three coherence states: Uncached, Shared or Modified. The entry does not keep one presence bit per processor. It holds a fixed number of sharer slots, and each slot stores a processor ID and a valid flag. The number of slots is a parameter of its own and does not grow when the processor count grows.

Requests arrive one at a time on a valid/ready stream. Each request carries an operation, a requesting processor and a line index.

- Reads and writes are answered on a grant stream.
- When other caches must give up or return a copy, the block first sends probes on a probe stream. Each probe is either an invalidation or a recall.
- It then counts acknowledgement pulses until every probe has been answered, and only then issues the grant.
- If a read arrives from a new sharer while every slot is occupied, the entry switches to a coarse mode in which the line is treated as shared by everyone. A later write then invalidates every processor except the writer.

Stream rules:

- A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is low from that acceptance until the transaction finishes.
- On the probe stream and the grant stream, a payload is held unchanged while its valid is high and its ready is low. The transfer happens on the cycle where both are high.
- Acknowledgements have no back-pressure.

Top module: `lpdir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `probe_valid` and `gnt_valid` are 0, and every line is Uncached. A write to an untouched line produces no probe and a grant with `gnt_excl`=1.
- R2: A read (`req_op`=0) to an Uncached or Shared line that is not in coarse mode records the requester in a free slot and returns a grant with `gnt_excl`=0, with no probe.
- R3: A read from a processor that is not listed, arriving while all NPTR slots are valid, puts the line in coarse mode and is still granted shared with no probe.
- R4: A read to a Modified line from a processor other than the owner first sends one probe with `probe_recall`=1 to the owner, then grants shared. Afterwards both the old owner and the reader are listed as sharers.
- R5: A write (`req_op`=1) to a Shared line that is not in coarse mode sends one invalidation (`probe_recall`=0) to each listed sharer other than the writer, in ascending processor ID order. It then grants with `gnt_excl`=1.
- R6: A write to a line in coarse mode sends invalidations to all processors except the writer, in ascending ID order, before granting exclusively.
- R7: After a write completes, the line is Modified, coarse mode is cleared, and the writer is the only listed processor. A write by another processor then invalidates only that writer.
- R8: An eviction (`req_op`=2) produces no probe and no grant. Outside coarse mode it removes the requester's slot. When no slot remains valid, the line becomes Uncached.
- R9: An eviction to a line in coarse mode leaves the entry unchanged, so a following write still invalidates all other processors.
- R10: Probe and grant payloads hold steady while valid is high and ready is low. `req_ready` is low while a probe or grant is pending.
- R11: A grant is not issued until one `ack_valid` pulse has been received for every probe sent for the request.
- R12: A read from a processor already listed for a line takes no extra slot and does not trigger coarse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_src | input | IDW (3) | Requesting processor ID |
| req_line | input | LW (2) | Line index |
| probe_valid | output | 1 | Probe offered |
| probe_ready | input | 1 | Probe taken when high together with probe_valid |
| probe_dst | output | IDW (3) | Processor the probe goes to |
| probe_line | output | LW (2) | Line the probe concerns |
| probe_recall | output | 1 | 1 recall dirty data, 0 invalidate |
| ack_valid | input | 1 | One pulse per answered probe |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Grant taken when high together with gnt_valid |
| gnt_dst | output | IDW (3) | Processor that receives the grant |
| gnt_line | output | LW (2) | Line granted |
| gnt_excl | output | 1 | 1 exclusive (Modified), 0 shared |

## Verification
The assertions assume that `ack_valid` pulses only in reply to probes already transferred, exactly once per probe, and never while the block is idle. They also assume that the probe and grant consumers do not rely on a payload changing while it stalls.

The bench keeps to these assumptions:

- It queues one owed acknowledgement for each observed probe transfer.
- It releases those acknowledgements on pseudo-random later cycles, or holds them back on purpose to stall the grant.
- It never pulses `ack_valid` when nothing is owed.

Ready on both output streams is toggled from a shift register, so every stall path is covered while the request stream stays within one outstanding transaction.

// File: rtl/lpdir_pkg.sv
package lpdir_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2
  } dir_op_e;

  typedef enum logic [1:0] {
    LS_UNC = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_PROBE = 2'd1,
    FS_GRANT = 2'd2
  } fsm_e;
endpackage

// File: rtl/lpdir_next.sv
// Combinational entry update: given the current entry and one request,
// produce the new entry, the probe target set and the grant kind.
module lpdir_next
  import lpdir_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int NPTR  = 2,
  localparam int IDW  = $clog2(NPROC),
  localparam int PW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [1:0]                cur_st,
  input  logic                      cur_coarse,
  input  logic [NPTR-1:0]           cur_v,
  input  logic [NPTR-1:0][IDW-1:0]  cur_id,
  input  logic [1:0]                op,
  input  logic [IDW-1:0]            src,
  output logic [1:0]                nxt_st,
  output logic                      nxt_coarse,
  output logic [NPTR-1:0]           nxt_v,
  output logic [NPTR-1:0][IDW-1:0]  nxt_id,
  output logic [NPROC-1:0]          mask,
  output logic                      recall,
  output logic                      need_gnt,
  output logic                      excl
);
  logic [NPTR-1:0] hit;
  logic            free_ok;
  logic [PW-1:0]   free_idx;

  always_comb begin
    hit      = '0;
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NPTR; i++) hit[i] = cur_v[i] && (cur_id[i] == src);
    for (int i = NPTR - 1; i >= 0; i--) begin
      if (!cur_v[i]) begin
        free_ok  = 1'b1;
        free_idx = PW'(i);
      end
    end
  end

  always_comb begin
    nxt_st     = cur_st;
    nxt_coarse = cur_coarse;
    nxt_v      = cur_v;
    nxt_id     = cur_id;
    mask       = '0;
    recall     = 1'b0;
    need_gnt   = 1'b0;
    excl       = 1'b0;
    unique case (op)
      OP_READ: begin
        need_gnt = 1'b1;
        if (cur_st == LS_MOD && cur_id[0] != src) begin
          // owner must return dirty data; both become sharers
          mask[cur_id[0]] = 1'b1;
          recall    = 1'b1;
          nxt_st    = LS_SHR;
          nxt_v     = '0;
          nxt_v[0]  = 1'b1;
          nxt_v[1]  = 1'b1;
          nxt_id[1] = src;
        end else if (cur_st == LS_MOD) begin
          excl = 1'b1;
        end else begin
          nxt_st = LS_SHR;
          if (!cur_coarse && hit == '0) begin
            if (free_ok) begin
              nxt_v[free_idx]  = 1'b1;
              nxt_id[free_idx] = src;
            end else begin
              nxt_coarse = 1'b1;
            end
          end
        end
      end
      OP_WRITE: begin
        need_gnt   = 1'b1;
        excl       = 1'b1;
        nxt_st     = LS_MOD;
        nxt_coarse = 1'b0;
        nxt_v      = '0;
        nxt_v[0]   = 1'b1;
        nxt_id     = '0;
        nxt_id[0]  = src;
        if (cur_coarse) begin
          mask      = '1;
          mask[src] = 1'b0;
        end else begin
          for (int i = 0; i < NPTR; i++)
            if (cur_v[i] && cur_id[i] != src) mask[cur_id[i]] = 1'b1;
        end
      end
      OP_EVICT: begin
        if (!cur_coarse) begin
          nxt_v = cur_v & ~hit;
          if ((cur_v & ~hit) == '0) nxt_st = LS_UNC;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpdir_probe_seq.sv
// Issues the probes of one request lowest ID first and counts acknowledgements.
module lpdir_probe_seq #(
  parameter int NPROC = 8,
  localparam int IDW  = $clog2(NPROC),
  localparam int CW   = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic             load_recall,
  output logic             probe_valid,
  input  logic             probe_ready,
  output logic [IDW-1:0]   probe_dst,
  output logic             probe_recall,
  input  logic             ack_valid,
  output logic             done
);
  logic [NPROC-1:0] mask_q;
  logic             recall_q;
  logic [CW-1:0]    need_q, got_q;

  always_comb begin
    probe_dst = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (mask_q[i]) probe_dst = IDW'(i);
  end

  assign probe_valid  = |mask_q;
  assign probe_recall = recall_q;
  assign done         = (mask_q == '0) && (got_q == need_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      recall_q <= 1'b0;
      need_q   <= '0;
      got_q    <= '0;
    end else if (load) begin
      mask_q   <= load_mask;
      recall_q <= load_recall;
      need_q   <= CW'($countones(load_mask));
      got_q    <= '0;
    end else begin
      if (probe_valid && probe_ready) mask_q[probe_dst] <= 1'b0;
      if (ack_valid && got_q != need_q) got_q <= got_q + 1'b1;
    end
  end

  // R10: a stalled probe keeps its payload
  p_probe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !probe_ready |=> probe_valid && $stable(probe_dst) && $stable(probe_recall));

  // R11: acknowledgements only arrive while some are still owed
  p_ack_expected_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !load |-> got_q != need_q);
endmodule

// File: rtl/lpdir_ctrl.sv
module lpdir_ctrl
  import lpdir_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int NPTR  = 2,
  parameter int NLINE = 4,
  localparam int IDW  = $clog2(NPROC),
  localparam int LW   = $clog2(NLINE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [IDW-1:0] req_src,
  input  logic [LW-1:0]  req_line,
  output logic           probe_valid,
  input  logic           probe_ready,
  output logic [IDW-1:0] probe_dst,
  output logic [LW-1:0]  probe_line,
  output logic           probe_recall,
  input  logic           ack_valid,
  output logic           gnt_valid,
  input  logic           gnt_ready,
  output logic [IDW-1:0] gnt_dst,
  output logic [LW-1:0]  gnt_line,
  output logic           gnt_excl
);
  logic [1:0]               lst_q    [NLINE];
  logic                     coarse_q [NLINE];
  logic [NPTR-1:0]          ptrv_q   [NLINE];
  logic [NPTR-1:0][IDW-1:0] ptrid_q  [NLINE];

  fsm_e           fsm_q;
  logic [LW-1:0]  line_q;
  logic [IDW-1:0] src_q;
  logic           excl_q;

  logic [1:0]               n_st;
  logic                     n_coarse;
  logic [NPTR-1:0]          n_v;
  logic [NPTR-1:0][IDW-1:0] n_id;
  logic [NPROC-1:0]         n_mask;
  logic                     n_recall, n_gnt, n_excl;
  logic                     acc, seq_done;

  assign req_ready = (fsm_q == FS_IDLE);
  assign acc       = req_valid && req_ready;

  lpdir_next #(.NPROC(NPROC), .NPTR(NPTR)) next_i (
    .cur_st    (lst_q[req_line]),
    .cur_coarse(coarse_q[req_line]),
    .cur_v     (ptrv_q[req_line]),
    .cur_id    (ptrid_q[req_line]),
    .op        (req_op),
    .src       (req_src),
    .nxt_st    (n_st),
    .nxt_coarse(n_coarse),
    .nxt_v     (n_v),
    .nxt_id    (n_id),
    .mask      (n_mask),
    .recall    (n_recall),
    .need_gnt  (n_gnt),
    .excl      (n_excl)
  );

  lpdir_probe_seq #(.NPROC(NPROC)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (acc),
    .load_mask   (n_mask),
    .load_recall (n_recall),
    .probe_valid (probe_valid),
    .probe_ready (probe_ready),
    .probe_dst   (probe_dst),
    .probe_recall(probe_recall),
    .ack_valid   (ack_valid),
    .done        (seq_done)
  );

  assign probe_line = line_q;
  assign gnt_valid  = (fsm_q == FS_GRANT);
  assign gnt_dst    = src_q;
  assign gnt_line   = line_q;
  assign gnt_excl   = excl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINE; l++) begin
        lst_q[l]    <= LS_UNC;
        coarse_q[l] <= 1'b0;
        ptrv_q[l]   <= '0;
        ptrid_q[l]  <= '0;
      end
    end else if (acc) begin
      lst_q[req_line]    <= n_st;
      coarse_q[req_line] <= n_coarse;
      ptrv_q[req_line]   <= n_v;
      ptrid_q[req_line]  <= n_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q  <= FS_IDLE;
      line_q <= '0;
      src_q  <= '0;
      excl_q <= 1'b0;
    end else begin
      unique case (fsm_q)
        FS_IDLE: if (acc) begin
          line_q <= req_line;
          src_q  <= req_src;
          excl_q <= n_excl;
          if (n_mask != '0) fsm_q <= FS_PROBE;
          else if (n_gnt)   fsm_q <= FS_GRANT;
        end
        FS_PROBE: if (seq_done) fsm_q <= FS_GRANT;
        FS_GRANT: if (gnt_ready) fsm_q <= FS_IDLE;
        default:  fsm_q <= FS_IDLE;
      endcase
    end
  end

  initial p_min_slots_r3: assert (NPTR >= 2);

  for (genvar g = 0; g < NLINE; g++) begin : g_line_chk
    // R7: a Modified line names exactly one owner
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lst_q[g] == LS_MOD |-> $countones(ptrv_q[g]) == 1);
    // R3: coarse mode only exists on a Shared line
    p_coarse_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      coarse_q[g] |-> lst_q[g] == LS_SHR);
  end

  // R10: a stalled grant keeps its payload
  p_gnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_dst) && $stable(gnt_excl) && $stable(gnt_line));
  // R10: no new request while output traffic is pending
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid || gnt_valid |-> !req_ready);
  // R11: grant never overlaps outstanding probes
  p_gnt_after_probes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> !gnt_valid);
  // R5: the requester is never probed
  p_no_self_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> probe_dst != src_q);
endmodule

// File: tb/lpdir_ctrl_tb.sv
module lpdir_ctrl_tb_top;
  localparam int NPROC = 8;
  localparam int IDW   = 3;
  localparam int LW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [IDW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic probe_valid, probe_ready = 1'b0, probe_recall;
  logic [IDW-1:0] probe_dst;
  logic [LW-1:0] probe_line;
  logic ack_valid = 1'b0;
  logic gnt_valid, gnt_ready = 1'b0, gnt_excl;
  logic [IDW-1:0] gnt_dst;
  logic [LW-1:0] gnt_line;

  always #2.5 clk = ~clk;

  lpdir_ctrl #(.NPROC(NPROC), .NPTR(2), .NLINE(4)) dut_i (.*);

  typedef struct packed {
    logic           g;
    logic [IDW-1:0] dst;
    logic           fl;
    logic [LW-1:0]  ln;
  } item_t;

  item_t exp_q[$];
  string rq_q[$];
  int n_chk = 0, n_fail = 0, ack_owed = 0;
  bit ack_en = 1'b1, running = 1'b0, ended = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_pv = 0, prev_pr = 0, prev_gv = 0, prev_gr = 0;
  logic [IDW-1:0] prev_pd = '0, prev_gd = '0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic exp_probe(int dst, bit rc, int ln, string rq);
    exp_q.push_back({1'b0, IDW'(dst), rc, LW'(ln)});
    rq_q.push_back(rq);
  endtask

  task automatic exp_gnt(int dst, bit ex, int ln, string rq);
    exp_q.push_back({1'b1, IDW'(dst), ex, LW'(ln)});
    rq_q.push_back(rq);
  endtask

  task automatic exp_bcast(int writer, int ln, string rq);
    for (int p = 0; p < NPROC; p++) if (p != writer) exp_probe(p, 1'b0, ln, rq);
  endtask

  task automatic wait_idle(string rq);
    int t = 0;
    while (!(req_ready && exp_q.size() == 0) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, rq, "transaction completes with all expected outputs", exp_q.size(), 0);
  endtask

  task automatic send(int op, int src, int ln);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op = 2'(op);
    req_src = IDW'(src);
    req_line = LW'(ln);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_req(int op, int src, int ln, string rq);
    send(op, src, ln);
    wait_idle(rq);
  endtask

  // monitor: drives readies and acks, then scores transfers
  always @(negedge clk) begin
    if (running) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      probe_ready = lfsr[0] | lfsr[3];
      gnt_ready = lfsr[1];
      if (ack_en && ack_owed > 0 && lfsr[2]) begin
        ack_valid = 1'b1;
        ack_owed--;
      end else ack_valid = 1'b0;
      if (prev_pv && !prev_pr)
        chk(probe_valid && probe_dst == prev_pd, "R10", "stalled probe held", int'(probe_dst), int'(prev_pd));
      if (prev_gv && !prev_gr)
        chk(gnt_valid && gnt_dst == prev_gd, "R10", "stalled grant held", int'(gnt_dst), int'(prev_gd));
      if (probe_valid || gnt_valid)
        chk(!req_ready, "R10", "req_ready low while busy", int'(req_ready), 0);
      if (probe_valid && probe_ready) begin
        item_t a;
        a = {1'b0, probe_dst, probe_recall, probe_line};
        ack_owed++;
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected probe", int'(a), 0);
        else chk(a == exp_q[0], rq_q[0], "probe {g,dst,recall,line}", int'(a), int'(exp_q[0]));
        if (exp_q.size() > 0) begin
          void'(exp_q.pop_front());
          void'(rq_q.pop_front());
        end
      end
      if (gnt_valid && gnt_ready) begin
        item_t a;
        a = {1'b1, gnt_dst, gnt_excl, gnt_line};
        if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected grant", int'(a), 0);
        else chk(a == exp_q[0], rq_q[0], "grant {g,dst,excl,line}", int'(a), int'(exp_q[0]));
        if (exp_q.size() > 0) begin
          void'(exp_q.pop_front());
          void'(rq_q.pop_front());
        end
      end
      prev_pv = probe_valid; prev_pr = probe_ready; prev_pd = probe_dst;
      prev_gv = gnt_valid;   prev_gr = gnt_ready;   prev_gd = gnt_dst;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(!probe_valid, "R1", "probe_valid after reset", int'(probe_valid), 0);
    chk(!gnt_valid, "R1", "gnt_valid after reset", int'(gnt_valid), 0);
    running = 1'b1;

    // R1: untouched line is Uncached; owner eviction returns it (R8)
    exp_gnt(0, 1, 3, "R1"); do_req(1, 0, 3, "R1");
    do_req(2, 0, 3, "R8");

    // line 0: sharers, repeat reader, invalidating write
    exp_gnt(1, 0, 0, "R2"); do_req(0, 1, 0, "R2");
    exp_gnt(2, 0, 0, "R2"); do_req(0, 2, 0, "R2");
    exp_gnt(1, 0, 0, "R12"); do_req(0, 1, 0, "R12");
    exp_probe(1, 0, 0, "R12"); exp_probe(2, 0, 0, "R5");
    exp_gnt(3, 1, 0, "R5"); do_req(1, 3, 0, "R5");
    exp_probe(3, 0, 0, "R7"); exp_gnt(5, 1, 0, "R7"); do_req(1, 5, 0, "R7");
    exp_probe(5, 1, 0, "R4"); exp_gnt(6, 0, 0, "R4"); do_req(0, 6, 0, "R4");
    exp_probe(5, 0, 0, "R4"); exp_probe(6, 0, 0, "R4");
    exp_gnt(0, 1, 0, "R4"); do_req(1, 0, 0, "R4");

    // line 1: overflow to coarse mode, broadcast write, then exact again
    exp_gnt(1, 0, 1, "R2"); do_req(0, 1, 1, "R2");
    exp_gnt(2, 0, 1, "R2"); do_req(0, 2, 1, "R2");
    exp_gnt(4, 0, 1, "R3"); do_req(0, 4, 1, "R3");
    exp_bcast(2, 1, "R6"); exp_gnt(2, 1, 1, "R6"); do_req(1, 2, 1, "R6");
    exp_probe(2, 0, 1, "R7"); exp_gnt(7, 1, 1, "R7"); do_req(1, 7, 1, "R7");

    // line 2: eviction of a sharer and of the owner
    exp_gnt(1, 0, 2, "R2"); do_req(0, 1, 2, "R2");
    exp_gnt(3, 0, 2, "R2"); do_req(0, 3, 2, "R2");
    do_req(2, 1, 2, "R8");
    exp_probe(3, 0, 2, "R8"); exp_gnt(6, 1, 2, "R8"); do_req(1, 6, 2, "R8");
    do_req(2, 6, 2, "R8");
    exp_gnt(4, 1, 2, "R8"); do_req(1, 4, 2, "R8");

    // line 3: coarse mode ignores eviction
    exp_gnt(0, 0, 3, "R2"); do_req(0, 0, 3, "R2");
    exp_gnt(1, 0, 3, "R2"); do_req(0, 1, 3, "R2");
    exp_gnt(2, 0, 3, "R3"); do_req(0, 2, 3, "R3");
    do_req(2, 0, 3, "R9");
    exp_bcast(5, 3, "R9"); exp_gnt(5, 1, 3, "R9"); do_req(1, 5, 3, "R9");

    // R11: grant waits for the acknowledgement
    begin
      int t = 0, seen = 0;
      ack_en = 1'b0;
      exp_probe(4, 0, 2, "R11"); exp_gnt(1, 1, 2, "R11");
      send(1, 1, 2);
      while (exp_q.size() > 1 && t < 1000) begin
        @(negedge clk);
        t++;
      end
      repeat (12) begin
        @(negedge clk);
        if (gnt_valid) seen++;
      end
      chk(seen == 0, "R11", "grant cycles before ack", seen, 0);
      ack_en = 1'b1;
      wait_idle("R11");
    end

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && ack_owed == 0, "R11", "all acks consumed", ack_owed, 0);
    finish_run();
  end
endmodule